// File: doc/BRIEF.md
# I2C Double-Buffered Data Flag Controller

This block keeps the byte-level data path of an I2C interface running without gaps. A transmit holding buffer feeds the outgoing shift register and a receive holding buffer takes bytes from the incoming shift register. Four status flags report where data sits: transmit buffer empty, transmit shift register full, receive buffer full and received byte parked in the shift register. The flags change on CPU accesses and on decoded bus events. These events are start, stop, the falling SCL edge of the first and of the last data bit, and the rising SCL edge of the acknowledge bit.

The CPU reaches the buffers through a plain data address and an alternate data address. A write goes to the transmit buffer and a read returns the receive buffer. When the alternate-path enable is set, the plain address is ignored and all traffic uses the alternate address. When a buffer cannot keep up, the block raises a clock-stretch request. This happens when the transmit buffer is empty at the first-bit fall, or when both receive stages are occupied after a byte completes. The request drops as soon as the CPU access that resolves it arrives.

Top module: `dbuf_flag_ctrl`

## Requirements
- R1: During and after synchronous active-low reset, all four flags, the stretch request and both strobes are 0.
- R2: A valid CPU write stores the data in the transmit buffer and clears the transmit-empty flag. A valid CPU read returns the receive buffer combinationally on `host_rdata`.
- R3: While `alt_path_en` is 1, reads and writes at the plain address change no buffer and no flag. The alternate address is honoured regardless of `alt_path_en`.
- R4: A start pulse sets the transmit-empty flag in transmit mode and leaves it unchanged in receive mode.
- R5: In master transmit mode, the acknowledge-bit rise of the first frame after a start sets the transmit-empty flag. Later frames' acknowledge rises leave it unchanged.
- R6: At a first-bit fall in transmit mode with the transmit buffer holding data, the block pulses `shift_load` for one cycle with that data on `shift_load_data`. It also sets both the transmit-empty and transmit-shift-full flags.
- R7: In transmit mode, an acknowledge-bit rise (bit number DATA_W+1) clears the transmit-shift-full flag.
- R8: A stop pulse clears all four flags and the stretch request.
- R9: At a last-bit fall (bit number DATA_W) in receive mode with the receive buffer empty, the byte moves into the receive buffer. The receive-full flag is set and `shift_unload` pulses for one cycle.
- R10: At a last-bit fall in receive mode with the receive buffer full, the byte is parked and the receive-shift-full flag is set. The stretch request is raised and the receive buffer keeps its old byte.
- R11: A valid read while a byte is parked moves the parked byte into the receive buffer. The receive-full flag stays 1, the receive-shift-full flag and the stretch request clear, and `shift_unload` pulses.
- R12: A valid read with no parked byte clears the receive-full flag.
- R13: A first-bit fall (bit number 1) in transmit mode with an empty transmit buffer raises the stretch request without a load. The next valid write loads that data at once, sets both transmit flags and clears the request.
- R14: When a CPU access and a bus event share a cycle, the access is applied first. A write alongside a first-bit fall loads the newly written byte. A read alongside a last-bit fall returns the old byte, then the new byte lands in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_main | input | 1 | CPU access targets the plain data address |
| host_sel_alt | input | 1 | CPU access targets the alternate data address |
| host_wr | input | 1 | CPU write strobe |
| host_rd | input | 1 | CPU read strobe |
| host_wdata | input | DATA_W | CPU write data |
| alt_path_en | input | 1 | Routes data traffic to the alternate address only |
| host_rdata | output | DATA_W | Receive buffer read data |
| bus_start | input | 1 | Start condition detected, one-cycle pulse |
| bus_stop | input | 1 | Stop condition detected, one-cycle pulse |
| scl_fall | input | 1 | SCL falling edge, one-cycle pulse |
| scl_rise | input | 1 | SCL rising edge, one-cycle pulse |
| bit_num | input | CNT_W | Bit number (1..DATA_W+1) of the current SCL edge |
| mode_master | input | 1 | 1 = master |
| mode_tx | input | 1 | 1 = transmit, 0 = receive |
| shift_rx_byte | input | DATA_W | Byte assembled by the receive shift register |
| tx_empty | output | 1 | Transmit buffer empty flag |
| tx_shift_full | output | 1 | Transmit shift register full flag |
| rx_full | output | 1 | Receive buffer full flag |
| rx_shift_full | output | 1 | Received byte parked in shift stage |
| tx_buf_q | output | DATA_W | Transmit buffer contents |
| rx_buf_q | output | DATA_W | Receive buffer contents |
| shift_load | output | 1 | One-cycle strobe: load transmit shift register |
| shift_load_data | output | DATA_W | Byte to load into the transmit shift register |
| shift_unload | output | 1 | One-cycle strobe: received byte taken into the buffer |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The assertions take for granted that bus events arrive as single-cycle pulses already synchronized to `clk`. They also assume that `bit_num` is valid whenever an SCL edge pulse is present. The bench drives every input just after a falling clock edge and clears each pulse one cycle later, so no pulse lasts longer than one cycle. It raises a last-bit fall in receive mode only while the parked stage is empty, as a stretched bus would. Each same-cycle collision it creates is one that the requirements order explicitly.

// File: rtl/dbuf_pkg.sv
// Shared types and bit-number helpers for the double-buffered flag controller.
// Assumes bit numbers count 1..DATA_W for data bits and DATA_W+1 for acknowledge.
package dbuf_pkg;

    typedef struct packed {
        logic empty;
        logic shfull;
        logic hold;
        logic first;
    } txst_t;

    typedef struct packed {
        logic full;
        logic shfull;
        logic hold;
    } rxst_t;

    function automatic int cnt_width(input int data_w);
        return $clog2(data_w + 2);
    endfunction

endpackage

// File: rtl/dbuf_evt_decode.sv
// Turns raw SCL edge pulses plus the bit number into the three frame events
// the flag logic reacts to. Assumes pulses are single-cycle and synchronous.
module dbuf_evt_decode #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = dbuf_pkg::cnt_width(DATA_W)
) (
    input  logic             scl_fall,
    input  logic             scl_rise,
    input  logic [CNT_W-1:0] bit_num,
    output logic             fall_first,
    output logic             fall_last,
    output logic             rise_ack
);
    localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_BIT   = CNT_W'(DATA_W + 1);

    // Match edge pulses against the three bit positions of interest.
    always_comb begin
        fall_first = scl_fall && (bit_num == FIRST_BIT);
        fall_last  = scl_fall && (bit_num == LAST_BIT);
        rise_ack   = scl_rise && (bit_num == ACK_BIT);
    end
endmodule

// File: rtl/dbuf_host_port.sv
// Qualifies CPU accesses against the alternate-path enable and returns the
// receive buffer as read data. Assumes sel/wr/rd are single-cycle strobes.
module dbuf_host_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_main,
    input  logic              sel_alt,
    input  logic              wr,
    input  logic              rd,
    input  logic              alt_en,
    input  logic [DATA_W-1:0] rx_buf,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [DATA_W-1:0] rdata
);
    logic addr_hit;

    // Plain address only counts while the alternate path is disabled.
    always_comb begin
        addr_hit = sel_alt || (sel_main && !alt_en);
        wr_ok    = addr_hit && wr;
        rd_ok    = addr_hit && rd;
        rdata    = rx_buf;
    end

    AST_MAIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && sel_main && !sel_alt) |-> (!wr_ok && !rd_ok)); // R3
endmodule

// File: rtl/dbuf_tx_path.sv
// Transmit holding buffer with empty / shift-full flags, load strobe and
// clock-stretch request. CPU write is applied first, bus events override.
module dbuf_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    input  logic              is_tx,
    input  logic              is_master,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              fall_first,
    input  logic              rise_ack,
    output logic              empty,
    output logic              shfull,
    output logic              hold,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] buf_q
);
    import dbuf_pkg::*;

    txst_t             st_q, st_n;
    logic              load_q, load_n;
    logic [DATA_W-1:0] buf_r, buf_n, ldat_q, ldat_n;

    // Next-state: CPU write, then start, first-bit fall, ack rise, stop.
    always_comb begin
        st_n   = st_q;
        buf_n  = buf_r;
        ldat_n = ldat_q;
        load_n = 1'b0;
        if (wr_ok) begin
            buf_n       = wdata;
            st_n.empty  = 1'b0;
            if (st_q.hold) begin
                load_n      = 1'b1;
                ldat_n      = wdata;
                st_n.empty  = 1'b1;
                st_n.shfull = 1'b1;
                st_n.hold   = 1'b0;
            end
        end
        if (ev_start) begin
            st_n.first = is_master;
            if (is_tx) st_n.empty = 1'b1;
        end
        if (is_tx && fall_first) begin
            if (!st_n.empty) begin
                load_n      = 1'b1;
                ldat_n      = buf_n;
                st_n.empty  = 1'b1;
                st_n.shfull = 1'b1;
            end else begin
                st_n.hold = 1'b1;
            end
        end
        if (is_tx && rise_ack) begin
            st_n.shfull = 1'b0;
            if (st_q.first && is_master) st_n.empty = 1'b1;
            st_n.first = 1'b0;
        end
        if (ev_stop) begin
            st_n = '0;
        end
    end

    // Flag and strobe registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            load_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            load_q <= load_n;
        end
    end

    // Data registers carry no reset; contents are undefined until written.
    always_ff @(posedge clk) begin
        buf_r  <= buf_n;
        ldat_q <= ldat_n;
    end

    assign empty     = st_q.empty;
    assign shfull    = st_q.shfull;
    assign hold      = st_q.hold;
    assign load      = load_q;
    assign load_data = ldat_q;
    assign buf_q     = buf_r;

    AST_LOAD_MARKS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> (st_q.empty && st_q.shfull)); // R6
    AST_STOP_IDLES_TX: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!empty && !shfull && !hold)); // R8
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !hold && !ev_start && !ev_stop && !fall_first && !rise_ack) |=> !empty); // R2
    AST_HOLD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_tx && fall_first && empty && !wr_ok && !ev_start && !ev_stop) |=> (hold && !load)); // R13
endmodule

// File: rtl/dbuf_rx_path.sv
// Receive holding buffer plus one parked byte in the shift stage, with full
// flags, unload strobe and clock-stretch request. CPU read applied first.
module dbuf_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ok,
    input  logic              is_tx,
    input  logic              ev_stop,
    input  logic              fall_last,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              full,
    output logic              shfull,
    output logic              hold,
    output logic              unload,
    output logic [DATA_W-1:0] buf_q
);
    import dbuf_pkg::*;

    rxst_t             st_q, st_n;
    logic              unl_q, unl_n;
    logic              byte_done;
    logic [DATA_W-1:0] buf_r, buf_n, park_q, park_n;

    // Next-state: CPU read drains first, then the completed byte, then stop.
    always_comb begin
        st_n      = st_q;
        buf_n     = buf_r;
        park_n    = park_q;
        unl_n     = 1'b0;
        byte_done = fall_last && !is_tx;
        if (rd_ok) begin
            if (st_q.shfull) begin
                buf_n       = park_q;
                st_n.shfull = 1'b0;
                st_n.hold   = 1'b0;
                unl_n       = 1'b1;
            end else begin
                st_n.full = 1'b0;
            end
        end
        if (byte_done) begin
            if (!st_n.full) begin
                buf_n     = rx_byte;
                st_n.full = 1'b1;
                unl_n     = 1'b1;
            end else begin
                park_n      = rx_byte;
                st_n.shfull = 1'b1;
                st_n.hold   = 1'b1;
            end
        end
        if (ev_stop) begin
            st_n = '0;
        end
    end

    // Flag and strobe registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            unl_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            unl_q <= unl_n;
        end
    end

    // Data registers carry no reset; contents are undefined until received.
    always_ff @(posedge clk) begin
        buf_r  <= buf_n;
        park_q <= park_n;
    end

    assign full   = st_q.full;
    assign shfull = st_q.shfull;
    assign hold   = st_q.hold;
    assign unload = unl_q;
    assign buf_q  = buf_r;

    AST_PARK_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        shfull |-> full); // R10
    AST_BYTE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_last && !is_tx && !ev_stop) |=> full); // R9
    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && shfull && !ev_stop && !(fall_last && !is_tx)) |=> (full && !shfull && !hold && unload)); // R11
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !shfull && !ev_stop && !(fall_last && !is_tx)) |=> !full); // R12
    AST_STOP_IDLES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!full && !shfull && !hold)); // R8
endmodule

// File: rtl/dbuf_flag_ctrl.sv
// Top of the double-buffered I2C data flag controller: decodes bus events,
// qualifies CPU accesses and runs the transmit and receive buffer paths.
// Assumes all bus event inputs are single-cycle pulses synchronous to clk.
module dbuf_flag_ctrl #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = dbuf_pkg::cnt_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_main,
    input  logic              host_sel_alt,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              alt_path_en,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              scl_fall,
    input  logic              scl_rise,
    input  logic [CNT_W-1:0]  bit_num,
    input  logic              mode_master,
    input  logic              mode_tx,
    input  logic [DATA_W-1:0] shift_rx_byte,
    output logic              tx_empty,
    output logic              tx_shift_full,
    output logic              rx_full,
    output logic              rx_shift_full,
    output logic [DATA_W-1:0] tx_buf_q,
    output logic [DATA_W-1:0] rx_buf_q,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_load_data,
    output logic              shift_unload,
    output logic              scl_hold
);
    logic wr_ok, rd_ok;
    logic fall_first, fall_last, rise_ack;
    logic tx_hold, rx_hold;

    dbuf_evt_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_evt (
        .scl_fall   (scl_fall),
        .scl_rise   (scl_rise),
        .bit_num    (bit_num),
        .fall_first (fall_first),
        .fall_last  (fall_last),
        .rise_ack   (rise_ack)
    );

    dbuf_host_port #(.DATA_W(DATA_W)) u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_main (host_sel_main),
        .sel_alt  (host_sel_alt),
        .wr       (host_wr),
        .rd       (host_rd),
        .alt_en   (alt_path_en),
        .rx_buf   (rx_buf_q),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .rdata    (host_rdata)
    );

    dbuf_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (wr_ok),
        .wdata      (host_wdata),
        .is_tx      (mode_tx),
        .is_master  (mode_master),
        .ev_start   (bus_start),
        .ev_stop    (bus_stop),
        .fall_first (fall_first),
        .rise_ack   (rise_ack),
        .empty      (tx_empty),
        .shfull     (tx_shift_full),
        .hold       (tx_hold),
        .load       (shift_load),
        .load_data  (shift_load_data),
        .buf_q      (tx_buf_q)
    );

    dbuf_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_ok     (rd_ok),
        .is_tx     (mode_tx),
        .ev_stop   (bus_stop),
        .fall_last (fall_last),
        .rx_byte   (shift_rx_byte),
        .full      (rx_full),
        .shfull    (rx_shift_full),
        .hold      (rx_hold),
        .unload    (shift_unload),
        .buf_q     (rx_buf_q)
    );

    // Either path may ask for SCL to be stretched.
    always_comb scl_hold = tx_hold || rx_hold;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tx_empty && !tx_shift_full && !rx_full && !rx_shift_full && !scl_hold)); // R1
endmodule

// File: tb/sim_dbuf_flag_ctrl.sv
// Scoreboard bench: driver tasks queue expected output values stamped with
// the cycle they must appear in; a monitor compares them at falling edges.
module sim_dbuf_flag_ctrl;
    localparam int DW = 8;
    localparam int CW = dbuf_pkg::cnt_width(DW);

    localparam int S_TE = 0, S_TS = 1, S_RF = 2, S_RS = 3, S_HOLD = 4,
                   S_LOAD = 5, S_LDAT = 6, S_UNLD = 7, S_TXB = 8, S_RXB = 9;

    typedef struct {
        int    cyc;
        int    sig;
        int    val;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_main = 0, sel_alt = 0, wr = 0, rd = 0, alt_en = 0;
    logic [DW-1:0] wdata = '0, rdata, rx_byte = '0;
    logic          b_start = 0, b_stop = 0, s_fall = 0, s_rise = 0;
    logic [CW-1:0] bnum = '0;
    logic          m_master = 0, m_tx = 0;
    logic          te, ts, rf, rs, shold, sload, sunl;
    logic [DW-1:0] txb, rxb, ldat;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sbq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbuf_flag_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_sel_main(sel_main), .host_sel_alt(sel_alt),
        .host_wr(wr), .host_rd(rd), .host_wdata(wdata),
        .alt_path_en(alt_en), .host_rdata(rdata),
        .bus_start(b_start), .bus_stop(b_stop),
        .scl_fall(s_fall), .scl_rise(s_rise), .bit_num(bnum),
        .mode_master(m_master), .mode_tx(m_tx), .shift_rx_byte(rx_byte),
        .tx_empty(te), .tx_shift_full(ts), .rx_full(rf), .rx_shift_full(rs),
        .tx_buf_q(txb), .rx_buf_q(rxb),
        .shift_load(sload), .shift_load_data(ldat),
        .shift_unload(sunl), .scl_hold(shold)
    );

    function automatic int observe(input int sig);
        case (sig)
            S_TE:    return int'(te);
            S_TS:    return int'(ts);
            S_RF:    return int'(rf);
            S_RS:    return int'(rs);
            S_HOLD:  return int'(shold);
            S_LOAD:  return int'(sload);
            S_LDAT:  return int'(ldat);
            S_UNLD:  return int'(sunl);
            S_TXB:   return int'(txb);
            default: return int'(rxb);
        endcase
    endfunction

    // Monitor: pop every item due this cycle and compare.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
            exp_t it;
            int   got;
            it  = sbq.pop_front();
            got = observe(it.sig);
            checks++;
            if (it.cyc != cyc || got != it.val) begin
                errors++;
                $display("FAIL %s sig%0d actual %0d expected %0d (cycle %0d)",
                         it.req, it.sig, got, it.val, cyc);
            end
        end
    end

    // Queue an expectation for the output registered at the next edge.
    task automatic expect_at(input int sig, input int val, input string req);
        exp_t it;
        it.cyc = cyc + 1;
        it.sig = sig;
        it.val = val;
        it.req = req;
        sbq.push_back(it);
    endtask

    // Hold the current stimulus for one clock, then clear all strobes.
    task automatic go();
        @(negedge clk);
        #1;
        sel_main = 0; sel_alt = 0; wr = 0; rd = 0;
        b_start = 0; b_stop = 0; s_fall = 0; s_rise = 0;
    endtask

    task automatic check_rdata(input logic [DW-1:0] exp_v, input string req);
        #1;
        checks++;
        if (rdata !== exp_v) begin
            errors++;
            $display("FAIL %s rdata actual %0h expected %0h", req, rdata, exp_v);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        expect_at(S_TE, 0, "R1"); expect_at(S_TS, 0, "R1");
        expect_at(S_RF, 0, "R1"); expect_at(S_RS, 0, "R1");
        expect_at(S_HOLD, 0, "R1"); expect_at(S_LOAD, 0, "R1");
        expect_at(S_UNLD, 0, "R1");
        rst_n = 1;
        go();

        // Receive mode start leaves TE alone (R4)
        m_tx = 0; m_master = 1;
        b_start = 1;
        expect_at(S_TE, 0, "R4");
        go();

        // Transmit master frame
        m_tx = 1;
        b_start = 1;
        expect_at(S_TE, 1, "R4");
        go();
        sel_main = 1; wr = 1; wdata = 8'hA5;
        expect_at(S_TE, 0, "R2"); expect_at(S_TXB, 8'hA5, "R2");
        go();
        s_fall = 1; bnum = CW'(1);
        expect_at(S_LOAD, 1, "R6"); expect_at(S_LDAT, 8'hA5, "R6");
        expect_at(S_TE, 1, "R6"); expect_at(S_TS, 1, "R6");
        go();
        sel_main = 1; wr = 1; wdata = 8'h3C;
        expect_at(S_TE, 0, "R2"); expect_at(S_LOAD, 0, "R6");
        go();
        s_rise = 1; bnum = CW'(DW + 1);
        expect_at(S_TE, 1, "R5"); expect_at(S_TS, 0, "R7");
        go();
        sel_main = 1; wr = 1; wdata = 8'h5A;
        expect_at(S_TE, 0, "R2");
        go();
        s_rise = 1; bnum = CW'(DW + 1);
        expect_at(S_TE, 0, "R5");
        go();

        // Alternate path enabled: plain write ignored (R3)
        alt_en = 1;
        sel_main = 1; wr = 1; wdata = 8'hFF;
        expect_at(S_TXB, 8'h5A, "R3"); expect_at(S_TE, 0, "R3");
        go();
        sel_alt = 1; wr = 1; wdata = 8'h66;
        expect_at(S_TXB, 8'h66, "R3");
        go();
        s_fall = 1; bnum = CW'(1);
        expect_at(S_LOAD, 1, "R6"); expect_at(S_LDAT, 8'h66, "R6");
        go();
        // Empty buffer at first-bit fall: stretch (R13)
        s_fall = 1; bnum = CW'(1);
        expect_at(S_HOLD, 1, "R13"); expect_at(S_LOAD, 0, "R13");
        go();
        sel_alt = 1; wr = 1; wdata = 8'h77;
        expect_at(S_LOAD, 1, "R13"); expect_at(S_LDAT, 8'h77, "R13");
        expect_at(S_HOLD, 0, "R13"); expect_at(S_TE, 1, "R13");
        expect_at(S_TS, 1, "R13");
        go();
        // Write together with first-bit fall loads new byte (R14)
        sel_alt = 1; wr = 1; wdata = 8'h12; s_fall = 1; bnum = CW'(1);
        expect_at(S_LOAD, 1, "R14"); expect_at(S_LDAT, 8'h12, "R14");
        expect_at(S_TE, 1, "R14"); expect_at(S_HOLD, 0, "R14");
        go();
        b_stop = 1;
        expect_at(S_TE, 0, "R8"); expect_at(S_TS, 0, "R8");
        expect_at(S_HOLD, 0, "R8");
        go();

        // Receive path
        m_tx = 0; alt_en = 0;
        s_fall = 1; bnum = CW'(DW); rx_byte = 8'h11;
        expect_at(S_RF, 1, "R9"); expect_at(S_RXB, 8'h11, "R9");
        expect_at(S_UNLD, 1, "R9");
        go();
        s_fall = 1; bnum = CW'(DW); rx_byte = 8'h22;
        expect_at(S_RS, 1, "R10"); expect_at(S_HOLD, 1, "R10");
        expect_at(S_RXB, 8'h11, "R10"); expect_at(S_UNLD, 0, "R10");
        go();
        sel_main = 1; rd = 1;
        check_rdata(8'h11, "R2");
        expect_at(S_RXB, 8'h22, "R11"); expect_at(S_RF, 1, "R11");
        expect_at(S_RS, 0, "R11"); expect_at(S_HOLD, 0, "R11");
        expect_at(S_UNLD, 1, "R11");
        go();
        sel_main = 1; rd = 1;
        check_rdata(8'h22, "R2");
        expect_at(S_RF, 0, "R12");
        go();

        // Plain read ignored while alternate path enabled (R3)
        alt_en = 1;
        s_fall = 1; bnum = CW'(DW); rx_byte = 8'h33;
        expect_at(S_RF, 1, "R9");
        go();
        sel_main = 1; rd = 1;
        expect_at(S_RF, 1, "R3");
        go();
        sel_alt = 1; rd = 1;
        check_rdata(8'h33, "R3");
        expect_at(S_RF, 0, "R3");
        go();

        // Read together with last-bit fall (R14)
        s_fall = 1; bnum = CW'(DW); rx_byte = 8'h44;
        expect_at(S_RF, 1, "R9");
        go();
        sel_alt = 1; rd = 1; s_fall = 1; bnum = CW'(DW); rx_byte = 8'h55;
        check_rdata(8'h44, "R14");
        expect_at(S_RF, 1, "R14"); expect_at(S_RS, 0, "R14");
        expect_at(S_RXB, 8'h55, "R14");
        go();
        s_fall = 1; bnum = CW'(DW); rx_byte = 8'h66;
        expect_at(S_RS, 1, "R10");
        go();
        b_stop = 1;
        expect_at(S_RF, 0, "R8"); expect_at(S_RS, 0, "R8");
        expect_at(S_HOLD, 0, "R8");
        go();

        repeat (3) @(negedge clk);
        #1;
        if (sbq.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard left %0d items", sbq.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule